// File: doc/BRIEF.md
# Digit-Scanned BCD Compare Timer

The block keeps a decimal time-of-cycle count and fires a single-cycle pulse when that count equals a stored target. The count is a chain of BCD digits that advances once per clock and rolls over to zero after its all-nines value. With six digits and a 1 MHz clock, one roll-over period is exactly one second, and the target resolves to one microsecond.

The target cannot be written in one go. An internal slow sequencer walks through the digit positions, from the most significant to the least significant, and then starts again. It raises one strobe per position for part of each slot. A controller watches the strobes (the combined strobe can serve as a single interrupt source) and presents a 4-bit BCD digit with a load strobe while the wanted position's strobe is high. A restart input sends the sequencer back to the most significant digit, so a load sequence can begin from a known place.

Top module: `scan_match_timer`

## Requirements
- R1: The internal count is zero during reset and advances by one on every rising clock edge once reset is released. It counts in decimal, and from the all-nines value it returns to zero, so the period is 10^NUM_DIGITS edges.
- R2: `match_pulse` is high after edge k (counting edges since reset release) exactly when the count held before edge k equals the stored target. With a steady target it is therefore high for one clock per period.
- R3: `digit_stb` is one-hot or zero. Bit i belongs to the decimal digit of weight 10^i. The active position moves one digit lower every SCAN_DIV edges and goes from bit 0 back to the top bit. In each slot the strobe is high after the first STB_HIGH edges and low after the remaining ones.
- R4: When `scan_set` is sampled high at edge e, the top bit of `digit_stb` is high after edges e to e+STB_HIGH-1, and the pattern of R3 continues from there. The first edge after reset behaves the same way.
- R5: `any_stb` is high exactly when some bit of `digit_stb` is high.
- R6: When `load_stb` is sampled high at an edge where bit i of `digit_stb` is high and `load_data` is 0 to 9, target digit i takes `load_data` from that edge on. The other digits keep their values.
- R7: A `load_stb` sampled while `digit_stb` is zero leaves the target unchanged.
- R8: A `load_data` value from 10 to 15 is refused: the selected digit keeps its previous value.
- R9: During reset, `digit_stb`, `any_stb` and `match_pulse` are low and the target is zero, so the first match follows edge 1 after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, one tick per count step |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_set | input | 1 | Restart the digit scan at the top digit |
| load_stb | input | 1 | Write the presented digit into the strobed position |
| load_data | input | 4 | BCD digit to write |
| digit_stb | output | NUM_DIGITS | Per-position load window, bit i for weight 10^i |
| any_stb | output | 1 | OR of all position strobes |
| match_pulse | output | 1 | One-clock pulse when the count equals the target |

## Verification
The bench builds the block with three digits, a scan slot of six clocks and a strobe width of three. A full count period is then 1000 edges, so several roll-overs fit in a short run. These include the match at the all-nines target and the match at zero right after reset. The short slot lets the bench follow several complete scan rotations edge by edge, including restarts and loads that land at the edges of the strobe window.

// File: rtl/scan_timer_pkg.sv
`timescale 1ns/1ps
package scan_timer_pkg;
    typedef logic [3:0] bcd_t;
    localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/bcd_counter.sv
`timescale 1ns/1ps
module bcd_counter #(
    parameter int unsigned NUM_DIGITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    output logic [NUM_DIGITS-1:0][3:0]  count_o
);
    import scan_timer_pkg::*;

    typedef struct packed {
        logic [NUM_DIGITS-1:0][3:0] digits;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [NUM_DIGITS-1:0] at_nine;
    logic [NUM_DIGITS-1:0] step_en;

    // a digit steps when every lower digit is at nine
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_carry
        assign at_nine[i] = (st_q.digits[i] == BCD_MAX);
        if (i == 0) begin : g_lsd
            assign step_en[i] = 1'b1;
        end else begin : g_upper
            assign step_en[i] = &at_nine[i-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (step_en[i]) begin
                st_d.digits[i] = at_nine[i] ? 4'd0 : st_q.digits[i] + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.digits;
endmodule

// File: rtl/digit_scanner.sv
`timescale 1ns/1ps
module digit_scanner #(
    parameter int unsigned NUM_DIGITS = 6,
    parameter int unsigned SCAN_DIV   = 50,
    parameter int unsigned STB_HIGH   = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_i,
    output logic [NUM_DIGITS-1:0] stb_o
);
    localparam int unsigned PTR_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;
    localparam int unsigned DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam logic [PTR_W-1:0] PTR_TOP  = PTR_W'(NUM_DIGITS - 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCAN_DIV - 1);
    localparam logic [DIV_W-1:0] HIGH_LIM = DIV_W'(STB_HIGH);

    typedef struct packed {
        logic [PTR_W-1:0]      ptr;
        logic [DIV_W-1:0]      div;
        logic [NUM_DIGITS-1:0] stb;
    } scan_state_t;

    scan_state_t st_d, st_q;
    logic [NUM_DIGITS-1:0] hit;

    // position decode of the next pointer
    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
        assign hit[i] = (st_d.ptr == PTR_W'(i));
    end

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.ptr = PTR_TOP;
            st_d.div = '0;
        end else if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            st_d.ptr = (st_q.ptr == '0) ? PTR_TOP : st_q.ptr - 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
        st_d.stb = (st_d.div < HIGH_LIM) ? hit : '0;
    end

    // reset parks at the end of the lowest slot so edge 1 opens the top digit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= '0;
            st_q.div <= DIV_LAST;
            st_q.stb <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;
endmodule

// File: rtl/compare_register.sv
`timescale 1ns/1ps
module compare_register #(
    parameter int unsigned NUM_DIGITS = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DIGITS-1:0]       sel_i,
    input  logic                        load_i,
    input  logic [3:0]                  data_i,
    input  logic [NUM_DIGITS-1:0][3:0]  count_i,
    output logic                        match_o
);
    import scan_timer_pkg::*;

    typedef struct packed {
        logic [NUM_DIGITS-1:0][3:0] target;
        logic                       match;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic [NUM_DIGITS-1:0] digit_eq;
    logic                  data_ok;

    assign data_ok = (data_i <= BCD_MAX);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_eq
        assign digit_eq[i] = (count_i[i] == st_q.target[i]);
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (load_i && sel_i[i] && data_ok) begin
                st_d.target[i] = data_i;
            end
        end
        st_d.match = &digit_eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o = st_q.match;
endmodule

// File: rtl/scan_match_timer.sv
`timescale 1ns/1ps
module scan_match_timer #(
    parameter int unsigned NUM_DIGITS = 6,
    parameter int unsigned SCAN_DIV   = 50,
    parameter int unsigned STB_HIGH   = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_set,
    input  logic                  load_stb,
    input  logic [3:0]            load_data,
    output logic [NUM_DIGITS-1:0] digit_stb,
    output logic                  any_stb,
    output logic                  match_pulse
);
    logic [NUM_DIGITS-1:0][3:0] count;

    bcd_counter #(.NUM_DIGITS(NUM_DIGITS)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count)
    );

    digit_scanner #(
        .NUM_DIGITS (NUM_DIGITS),
        .SCAN_DIV   (SCAN_DIV),
        .STB_HIGH   (STB_HIGH)
    ) u_scanner (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (scan_set),
        .stb_o (digit_stb)
    );

    compare_register #(.NUM_DIGITS(NUM_DIGITS)) u_compare (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (digit_stb),
        .load_i  (load_stb),
        .data_i  (load_data),
        .count_i (count),
        .match_o (match_pulse)
    );

    assign any_stb = |digit_stb;
endmodule

// File: rtl/scan_match_timer_chk.sv
`timescale 1ns/1ps
module scan_match_timer_chk #(
    parameter int unsigned NUM_DIGITS = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_set,
    input logic [NUM_DIGITS-1:0] digit_stb,
    input logic                  match_pulse
);
    logic [NUM_DIGITS-1:0] last_stb_q;
    logic                  seen_q;
    logic [NUM_DIGITS-1:0] next_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_stb_q <= '0;
            seen_q     <= 1'b0;
        end else if (digit_stb != '0) begin
            last_stb_q <= digit_stb;
            seen_q     <= 1'b1;
        end
    end

    assign next_stb = {last_stb_q[0], last_stb_q[NUM_DIGITS-1:1]};

    p_stb_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_stb));

    p_stb_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(|digit_stb) && !$past(scan_set) && seen_q) |-> (digit_stb == next_stb));

    p_set_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_set |=> digit_stb[NUM_DIGITS-1]);

    p_match_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);
endmodule

bind scan_match_timer scan_match_timer_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_set    (scan_set),
    .digit_stb   (digit_stb),
    .match_pulse (match_pulse)
);

// File: tb/scan_match_timer_bench.sv
`timescale 1ns/1ps
module scan_match_timer_bench;
    localparam int unsigned ND = 3;
    localparam int unsigned SD = 6;
    localparam int unsigned SH = 3;
    localparam int          PERIOD = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_set = 1'b0;
    logic load_stb = 1'b0;
    logic [3:0] load_data = 4'd0;
    logic [ND-1:0] digit_stb;
    logic any_stb;
    logic match_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R9";
    int reg_model = 0;
    int drv_val = 0;
    int q_edge[$];
    int q_val[$];

    always #2.5 clk = ~clk;

    scan_match_timer #(.NUM_DIGITS(ND), .SCAN_DIV(SD), .STB_HIGH(SH)) u_scan_match_timer (
        .clk (clk), .rst_n (rst_n), .scan_set (scan_set), .load_stb (load_stb),
        .load_data (load_data), .digit_stb (digit_stb), .any_stb (any_stb),
        .match_pulse (match_pulse)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at edge %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    function automatic int pow10(int d);
        int r = 1;
        for (int i = 0; i < d; i++) r = r * 10;
        return r;
    endfunction

    // monitor: compares match against the target model, then applies queued loads
    always @(negedge clk) begin
        bit exp_m;
        exp_m = 1'b0;
        if (rst_n && !done) begin
            exp_m = (cyc >= 1) && (((cyc - 1) % PERIOD) == reg_model);
            if (exp_m || match_pulse)
                check(match_pulse == exp_m, {"R2/", tag}, "match_pulse", int'(match_pulse), int'(exp_m));
            while (q_edge.size() > 0 && q_edge[0] == cyc) begin
                reg_model = q_val[0];
                void'(q_edge.pop_front());
                void'(q_val.pop_front());
            end
        end
    end

    task automatic pulse_set();
        scan_set = 1'b1;
        @(negedge clk);
        scan_set = 1'b0;
    endtask

    // driver: writes a value digit by digit, pushing each register change it causes
    task automatic load_value(int v);
        pulse_set();
        for (int d = ND - 1; d >= 0; d--) begin
            int p;
            int dig;
            p = pow10(d);
            dig = (v / p) % 10;
            while (digit_stb[d] !== 1'b1) @(negedge clk);
            load_data = 4'(dig);
            load_stb = 1'b1;
            drv_val = drv_val - ((drv_val / p) % 10) * p + dig * p;
            q_edge.push_back(cyc + 1);
            q_val.push_back(drv_val);
            @(negedge clk);
            load_stb = 1'b0;
        end
    endtask

    task automatic check_scan();
        pulse_set();
        for (int t = 0; t < int'(2 * SD * ND); t++) begin
            int s;
            int j;
            logic [ND-1:0] exp_s;
            s = (t / SD) % ND;
            j = t % SD;
            exp_s = (j < SH) ? ND'(1 << (ND - 1 - s)) : '0;
            if (t == 0) check(digit_stb == exp_s, "R4", "digit_stb after set", int'(digit_stb), int'(exp_s));
            else        check(digit_stb == exp_s, "R3", "digit_stb scan", int'(digit_stb), int'(exp_s));
            check(any_stb == (exp_s != '0), "R5", "any_stb", int'(any_stb), int'(exp_s != '0));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(digit_stb == '0, "R9", "digit_stb in reset", int'(digit_stb), 0);
        check(any_stb == 1'b0, "R9", "any_stb in reset", int'(any_stb), 0);
        check(match_pulse == 1'b0, "R9", "match_pulse in reset", int'(match_pulse), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(digit_stb == ND'(1 << (ND - 1)), "R4", "first strobe after reset", int'(digit_stb), 1 << (ND - 1));
        repeat (5) @(negedge clk);
        tag = "R1";
        while (cyc < 1005) @(negedge clk);
        tag = "R3";
        check_scan();
        tag = "R6";
        load_value(345);
        repeat (1100) @(negedge clk);
        load_value(999);
        repeat (1100) @(negedge clk);
        tag = "R7";
        while (any_stb !== 1'b0) @(negedge clk);
        load_data = 4'd7;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        repeat (1100) @(negedge clk);
        tag = "R8";
        pulse_set();
        while (digit_stb[0] !== 1'b1) @(negedge clk);
        load_data = 4'hC;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        repeat (1100) @(negedge clk);
        tag = "R6";
        load_value(5);
        repeat (1100) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule